// File: doc/BRIEF.md
# Hybrid Hardware/Software Clock Gate

This block gates one clock and is controlled through a single 32-bit register. Software chooses who owns the gate. In automatic mode the gate opens and closes with a hardware activity request. In manual mode it follows an enable bit that software writes. A read-only status bit shows whether the gate is really open. Software polls that bit until a change it asked for has taken effect.

The gating cell uses a latch that is open only while the input clock is low. A change in the request therefore never cuts a high phase short. The gate state is moved into the register clock domain through two flops, so the status bit trails the real gate.

A build parameter picks one of four variants:

- no gate at all
- manual only
- automatic only
- selectable at run time

For the selectable variant, a second parameter chooses whether it comes out of reset in automatic or in manual mode.

Top module: `hsw_clk_gate`

## Requirements
- R1: Out of reset, a gate that starts in manual mode has its enable bit set to 1 and its gate open. A gate that starts in automatic mode follows the request input. The status bit starts at the gate's reset state.
- R2: In manual mode (mode bit 1 = 1 in the selectable variant, and always in the manual-only variant), `clk_out` follows enable bit 0: 1 runs the clock and 0 stops it. The clock high phase that follows the write edge still shows the old state. The next high phase shows the new state.
- R3: In automatic mode (mode bit 1 = 0), `clk_out` follows `hw_req` and the enable bit has no effect on it.
- R4: Status bit 2 is read-only and reports the gate state. When both clocks are the same, it changes on the third register clock edge after the write edge, and the second edge still shows the old state.
- R5: `clk_out` is low whenever `clk_in` is low. `clk_out` never changes during a high phase of `clk_in`.
- R6: `KIND` selects the variant: 0 = no gate, 1 = manual only, 2 = automatic only, 3 = selectable. With no gate, `clk_out` equals `clk_in` and status always reads 1.
- R7: Writes to bits the chosen variant lacks are ignored. Those bits read as 0:
  - enable bit 0 in variants 0 and 2
  - mode bit 1 in variants 0, 1 and 2
  - bits 31:3 in every variant
- R8: With `START_HW` = 1, a selectable gate leaves reset in automatic mode with its enable bit still set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DW | Register write data |
| rd_data | output | DW | Register read data: bit 0 enable, bit 1 mode, bit 2 status |
| clk_in | input | 1 | Clock to be gated |
| hw_req | input | 1 | Hardware activity request, synchronous to `clk_in` |
| clk_out | output | 1 | Gated clock |

## Verification
Two events can arrive in the same cycle: a register write that changes the enable or mode bit, and a change on `hw_req`. The bench makes both happen in the same low phase of the clock, across every 3-bit write value and both request levels. It does this for all five built variants, which are driven from one shared bus.

For each case, the bench computes the winning request arithmetically from the variant and the mode. It then checks three things:

- the gated high phase before the change and the one after it
- that the low phase stays low
- that the status lags the change by exactly the synchronizer depth

// File: rtl/hsw_clk_gate.sv
module hsw_clk_gate #(
  parameter int KIND     = 3,
  parameter bit START_HW = 1'b0,
  parameter int DW       = 32
) (
  input  logic          reg_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          clk_in,
  input  logic          hw_req,
  output logic          clk_out
);
  localparam int  EN_B     = 0;
  localparam int  SEL_B    = 1;
  localparam int  STS_B    = 2;
  localparam bit  HAS_GATE = (KIND != 0);
  localparam bit  HAS_EN   = (KIND == 1) || (KIND == 3);
  localparam bit  HAS_SEL  = (KIND == 3);
  localparam bit  SEL_RST  = HAS_SEL ? !START_HW : (KIND == 1);
  localparam bit  GATE_RST = (KIND == 0) || SEL_RST;

  logic en_q, sel_q, req;
  logic gate_lat, gate_q;
  logic sync1, sync2;

  always_ff @(posedge reg_clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= HAS_EN;
      sel_q <= SEL_RST;
    end else if (wr_en) begin
      if (HAS_EN)  en_q  <= wr_data[EN_B];
      if (HAS_SEL) sel_q <= wr_data[SEL_B];
    end

  assign req = sel_q ? en_q : hw_req;

  generate
    if (HAS_GATE) begin : g_cell
      always_latch
        if (!rst_n)       gate_lat = GATE_RST;
        else if (!clk_in) gate_lat = req;

      always_ff @(posedge clk_in or negedge rst_n)
        if (!rst_n) gate_q <= GATE_RST;
        else        gate_q <= gate_lat;

      assign clk_out = clk_in & gate_lat;
    end else begin : g_none
      assign gate_lat = 1'b1;
      assign gate_q   = 1'b1;
      assign clk_out  = clk_in;
    end
  endgenerate

  always_ff @(posedge reg_clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= GATE_RST;
      sync2 <= GATE_RST;
    end else begin
      sync1 <= gate_q;
      sync2 <= sync1;
    end

  always_comb begin
    rd_data        = '0;
    rd_data[EN_B]  = HAS_EN & en_q;
    rd_data[SEL_B] = HAS_SEL & sel_q;
    rd_data[STS_B] = HAS_GATE ? sync2 : 1'b1;
  end

  logic unused_wr;
  assign unused_wr = ^wr_data[DW-1:SEL_B+1];
endmodule

module hsw_clk_gate_chk #(
  parameter int KIND = 3,
  parameter int DW   = 32
) (
  input logic          reg_clk,
  input logic          clk_in,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          gate_lat,
  input logic          gate_q
);
  localparam bit HAS_EN  = (KIND == 1) || (KIND == 3);
  localparam bit HAS_SEL = (KIND == 3);

  p_hold_high_r5: assert property (@(negedge clk_in) disable iff (!rst_n)
    gate_lat == gate_q);

  p_en_write_r2: assert property (@(posedge reg_clk) disable iff (!rst_n)
    wr_en |=> rd_data[0] == (HAS_EN & $past(wr_data[0])));

  p_sel_write_r3: assert property (@(posedge reg_clk) disable iff (!rst_n)
    wr_en |=> rd_data[1] == (HAS_SEL & $past(wr_data[1])));

  p_nogate_sts_r6: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (KIND == 0) |-> rd_data[2]);

  p_hi_bits_r7: assert property (@(posedge reg_clk) disable iff (!rst_n)
    wr_en && (wr_data[DW-1:3] != 0) |=> rd_data[DW-1:3] == 0);
endmodule

bind hsw_clk_gate hsw_clk_gate_chk #(.KIND(KIND), .DW(DW)) u_chk (
  .reg_clk(reg_clk), .clk_in(clk_in), .rst_n(rst_n), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .gate_lat(gate_lat), .gate_q(gate_q));

// File: tb/sim_hsw_clk_gate.sv
`timescale 1ns/1ps
module sim_hsw_clk_gate;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, hw_req = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd [5];
  logic        co [5];
  int checks = 0, errors = 0;
  bit done = 0;
  int kinds [5] = '{3, 1, 2, 0, 3};
  logic prev [5] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

  always #2.5 clk = ~clk;

  hsw_clk_gate #(.KIND(3), .START_HW(1'b0)) u0 (.reg_clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd[0]), .clk_in(clk), .hw_req(hw_req), .clk_out(co[0]));
  hsw_clk_gate #(.KIND(1)) u1 (.reg_clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd[1]), .clk_in(clk), .hw_req(hw_req), .clk_out(co[1]));
  hsw_clk_gate #(.KIND(2)) u2 (.reg_clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd[2]), .clk_in(clk), .hw_req(hw_req), .clk_out(co[2]));
  hsw_clk_gate #(.KIND(0)) u3 (.reg_clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd[3]), .clk_in(clk), .hw_req(hw_req), .clk_out(co[3]));
  hsw_clk_gate #(.KIND(3), .START_HW(1'b1)) u4 (.reg_clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd[4]), .clk_in(clk), .hw_req(hw_req), .clk_out(co[4]));

  task automatic chk(string tag, int i, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s u%0d actual=%h expected=%h", tag, i, act, exp);
    end
  endtask

  function automatic logic exp_req(int k, logic [2:0] d, logic h);
    case (k)
      0: return 1'b1;
      1: return d[0];
      2: return h;
      default: return d[1] ? d[0] : h;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int k, logic [2:0] d, logic h);
    logic [31:0] r = '0;
    r[0] = (k == 1 || k == 3) ? d[0] : 1'b0;
    r[1] = (k == 3) ? d[1] : 1'b0;
    r[2] = exp_req(k, d, h);
    return r;
  endfunction

  function automatic string clk_tag(int k, logic [2:0] d);
    if (k == 0) return "R6";
    if (k == 2 || (k == 3 && !d[1])) return "R3";
    return "R2";
  endfunction

  task automatic step(logic [2:0] d, logic h);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {29'h1FFF_FFFF, d};
    @(posedge clk); #1;
    for (int i = 0; i < 5; i++) chk("R5 old high phase", i, 32'(co[i]), 32'(prev[i]));
    @(negedge clk);
    wr_en = 1'b0;
    hw_req = h;
    #1;
    for (int i = 0; i < 5; i++) chk("R5 low phase", i, 32'(co[i]), 32'd0);
    @(posedge clk); #1;
    for (int i = 0; i < 5; i++)
      chk(clk_tag(kinds[i], d), i, 32'(co[i]), 32'(exp_req(kinds[i], d, h)));
    @(posedge clk); #1;
    for (int i = 0; i < 5; i++) chk("R4 lag", i, 32'(rd[i][2]), 32'(prev[i]));
    @(posedge clk); #1;
    for (int i = 0; i < 5; i++) chk("R4 R7 readback", i, rd[i], exp_rd(kinds[i], d, h));
    for (int i = 0; i < 5; i++) prev[i] = exp_req(kinds[i], d, h);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1", 0, rd[0], 32'h7);
    chk("R1", 1, rd[1], 32'h5);
    chk("R1", 2, rd[2], 32'h0);
    chk("R6", 3, rd[3], 32'h4);
    chk("R8", 4, rd[4], 32'h1);
    chk("R1", 0, 32'(co[0]), 32'd1);
    chk("R1", 2, 32'(co[2]), 32'd0);
    chk("R8", 4, 32'(co[4]), 32'd0);
    for (int pass = 0; pass < 2; pass++)
      for (int n = 0; n < 16; n++) begin
        int v = pass ? 15 - n : n;
        step(3'(v >> 1), v[0]);
      end
    step(3'b011, 1'b0);
    step(3'b001, 1'b1);
    step(3'b000, 1'b1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule